// File: doc/BRIEF.md
# Task Switch Commit Sequencer

This block steers the segment-state portion of a hardware task switch. On a start request it first reads and validates the descriptor of the incoming task-state segment. If that succeeds, it passes the commit point: the task register takes the new selector and, for a nested switch (a call or an interrupt), the back-link field of the new task-state segment is written with the outgoing selector. It then fetches all seven segment selectors from the new task-state segment into the segment register file. Only after all seven are loaded does it check their descriptors one at a time, in a fixed order.

All memory traffic goes through one request/response port. A request stays asserted with stable fields until a response-valid cycle is seen. A failure is reported as a one-cycle fault pulse with a vector, an error code and a context flag. The context flag tells whether the fault belongs to the outgoing task (saved IP is the instruction that began the switch) or to the new task (saved IP is the first instruction of the new task). A clean run ends in a one-cycle done pulse.

Top module: `task_switch_seq`

## Requirements
- R1: After reset, no request is raised, the task register and all seven segment slots read zero, and neither done nor fault is asserted.
- R2: The first request of a switch has kind 0 (descriptor read of the new task-state segment) and address equal to the new selector. The response uses bit 0 as present and bit 1 as limit-ok. If present is clear the fault vector is 11; if only limit-ok is clear it is 10. The error code is the new selector with bits 1:0 cleared, the context flag is 0, and the task register and segment slots keep their earlier values.
- R3: After a good task-state descriptor, the task register holds the new selector. A nested switch then issues one request of kind 1 with address equal to the new selector and write data equal to the outgoing selector. A non-nested switch issues no such request.
- R4: After commit, seven requests of kind 2 follow with addresses 0 to 6. Each response becomes segment slot n, with slot order LDTR, SS, CS, DS, ES, FS, GS; slot n sits at bits 16n+15:16n of the slot bus. No descriptor check starts before all seven are loaded, and no slot changes while checks run.
- R5: Checks are requests of kind 3 whose address is the selector held in the slot being checked. They are issued in slot order 0 to 6 and stop at the first failing slot.
- R6: A post-commit failure gives vector 10 for the LDTR slot and 12 for the SS slot. Any other slot gives 11 when present is clear and 10 otherwise. The error code is the failing selector with bits 1:0 cleared and the context flag is 1.
- R7: A stack-segment fault always carries the new-task context. After a post-commit fault, all seven slots keep the values fetched, including the slots never checked.
- R8: Done pulses for exactly one cycle only when all seven checks pass. Fault pulses for exactly one cycle. The two are never high together.
- R9: A request held without a response keeps its kind and address unchanged in the next cycle. A start seen while a switch is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a switch (sampled when idle) |
| nest_i | input | 1 | Switch is due to a call or interrupt |
| new_sel_i | input | 16 | Selector of the incoming task-state segment |
| old_sel_i | input | 16 | Selector of the outgoing task-state segment |
| req_valid_o | output | 1 | Memory request pending |
| req_kind_o | output | 2 | 0 tss desc, 1 link write, 2 selector fetch, 3 desc read |
| req_addr_o | output | 16 | Selector or slot number of the request |
| req_wdata_o | output | 16 | Write data for the link write |
| rsp_valid_i | input | 1 | Response accepts the pending request |
| rsp_data_i | input | 16 | Response data |
| tr_sel_o | output | 16 | Task register selector |
| seg_sel_o | output | 112 | Seven segment selector slots |
| done_o | output | 1 | Switch completed with all checks passed |
| fault_o | output | 1 | Fault pulse |
| fault_vec_o | output | 8 | Fault vector |
| fault_code_o | output | 16 | Error code (selector, low two bits clear) |
| fault_new_task_o | output | 1 | 1: fault in new task, save its first IP |

## Verification
On every cycle the assertions check that done and fault are exclusive single-cycle pulses and that pending requests hold steady. They also check that the task register stays still during the task-state descriptor read, that the link write names the committed selector, that no slot changes during checking, and that a stack-segment fault is always in new-task context. Only the bench scenarios show the full request order, the vector mapping for each slot and failure type, the untouched state after a pre-commit fault, and the retained unchecked slots after a post-commit fault.

// File: rtl/tsc_pkg.sv
// Shared types and constants of the task switch commit sequencer.
package tsc_pkg;
    typedef enum logic [1:0] {
        K_TSS  = 2'd0,
        K_LINK = 2'd1,
        K_SEL  = 2'd2,
        K_DESC = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_VERIFY, S_COMMIT, S_LOAD, S_CHECK, S_DONE, S_FAULT
    } state_e;

    localparam logic [7:0] V_TS = 8'd10;
    localparam logic [7:0] V_NP = 8'd11;
    localparam logic [7:0] V_SS = 8'd12;
    localparam int SLOT_LDT = 0;
    localparam int SLOT_SS  = 1;
endpackage

// File: rtl/tsc_check.sv
// Classifies one descriptor response into pass/fail and a fault vector.
// Assumes response bit 0 = present, bit 1 = limit ok; slot order LDTR, SS, ...
module tsc_check
    import tsc_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  logic              is_tss_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              present_i,
    input  logic              lim_ok_i,
    output logic              fail_o,
    output logic [7:0]        vec_o
);
    // Pick vector by descriptor role and failure kind.
    always_comb begin
        fail_o = !(present_i && lim_ok_i);
        if (is_tss_i)
            vec_o = present_i ? V_TS : V_NP;
        else if (slot_i == SLOT_W'(SLOT_LDT))
            vec_o = V_TS;
        else if (slot_i == SLOT_W'(SLOT_SS))
            vec_o = V_SS;
        else
            vec_o = present_i ? V_TS : V_NP;
    end
endmodule

// File: rtl/tsc_segfile.sv
// Holds the task register and the segment selector slots.
// Assumes at most one slot write per cycle; reads are combinational.
module tsc_segfile #(
    parameter int SEL_W = 16,
    parameter int NSEG  = 7,
    localparam int SLOT_W = $clog2(NSEG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tr_we_i,
    input  logic [SEL_W-1:0]      tr_wdata_i,
    input  logic                  seg_we_i,
    input  logic [SLOT_W-1:0]     seg_widx_i,
    input  logic [SEL_W-1:0]      seg_wdata_i,
    input  logic [SLOT_W-1:0]     rd_idx_i,
    output logic [SEL_W-1:0]      rd_sel_o,
    output logic [SEL_W-1:0]      tr_sel_o,
    output logic [NSEG*SEL_W-1:0] seg_flat_o
);
    logic [SEL_W-1:0] slot_q [NSEG];

    // Task register update at commit.
    always_ff @(posedge clk) begin
        if (!rst_n)       tr_sel_o <= '0;
        else if (tr_we_i) tr_sel_o <= tr_wdata_i;
    end

    for (genvar g = 0; g < NSEG; g++) begin : g_slot
        // One slot register, written during the load phase.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (seg_we_i && seg_widx_i == SLOT_W'(g))
                slot_q[g] <= seg_wdata_i;
        end
        assign seg_flat_o[g*SEL_W +: SEL_W] = slot_q[g];
    end

    assign rd_sel_o = slot_q[rd_idx_i];
endmodule

// File: rtl/tsc_fsm.sv
// Sequencer: verify new TSS, commit, load all slots, then check them in order.
// Assumes the responder answers each request with a one-cycle rsp_valid_i.
module tsc_fsm
    import tsc_pkg::*;
#(
    parameter int SEL_W = 16,
    parameter int NSEG  = 7,
    localparam int SLOT_W = $clog2(NSEG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              nest_i,
    input  logic [SEL_W-1:0]  new_sel_i,
    input  logic [SEL_W-1:0]  old_sel_i,
    output logic              req_valid_o,
    output logic [1:0]        req_kind_o,
    output logic [SEL_W-1:0]  req_addr_o,
    output logic [SEL_W-1:0]  req_wdata_o,
    input  logic              rsp_valid_i,
    input  logic [SEL_W-1:0]  rsp_data_i,
    input  logic [SEL_W-1:0]  cur_sel_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic              tr_we_o,
    output logic              seg_we_o,
    output logic              done_o,
    output logic              fault_o,
    output logic [7:0]        fault_vec_o,
    output logic [SEL_W-1:0]  fault_code_o,
    output logic              fault_new_task_o
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NSEG - 1);
    localparam logic [SEL_W-1:0]  RPL_MASK = ~SEL_W'(3);

    state_e            state_q;
    logic [SLOT_W-1:0] slot_q;
    logic [SEL_W-1:0]  new_q, old_q;
    logic              nest_q;
    logic              chk_fail;
    logic [7:0]        chk_vec;

    tsc_check #(.SLOT_W(SLOT_W)) u_chk (
        .is_tss_i (state_q == S_VERIFY),
        .slot_i   (slot_q),
        .present_i(rsp_data_i[0]),
        .lim_ok_i (rsp_data_i[1]),
        .fail_o   (chk_fail),
        .vec_o    (chk_vec)
    );

    // Drive the request port from the current state.
    always_comb begin
        req_valid_o = 1'b0;
        req_kind_o  = K_TSS;
        req_addr_o  = new_q;
        req_wdata_o = '0;
        case (state_q)
            S_VERIFY: req_valid_o = 1'b1;
            S_COMMIT: begin
                req_valid_o = nest_q;
                req_kind_o  = K_LINK;
                req_wdata_o = old_q;
            end
            S_LOAD: begin
                req_valid_o = 1'b1;
                req_kind_o  = K_SEL;
                req_addr_o  = SEL_W'(slot_q);
            end
            S_CHECK: begin
                req_valid_o = 1'b1;
                req_kind_o  = K_DESC;
                req_addr_o  = cur_sel_i;
            end
            default: ;
        endcase
    end

    // Register-file strobes and completion pulses.
    assign tr_we_o  = (state_q == S_VERIFY) && rsp_valid_i && !chk_fail;
    assign seg_we_o = (state_q == S_LOAD) && rsp_valid_i;
    assign slot_o   = slot_q;
    assign done_o   = (state_q == S_DONE);
    assign fault_o  = (state_q == S_FAULT);

    // State, slot counter, latched request and fault report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q          <= S_IDLE;
            slot_q           <= '0;
            new_q            <= '0;
            old_q            <= '0;
            nest_q           <= 1'b0;
            fault_vec_o      <= '0;
            fault_code_o     <= '0;
            fault_new_task_o <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: if (start_i) begin
                    new_q   <= new_sel_i;
                    old_q   <= old_sel_i;
                    nest_q  <= nest_i;
                    slot_q  <= '0;
                    state_q <= S_VERIFY;
                end
                S_VERIFY: if (rsp_valid_i) begin
                    if (chk_fail) begin
                        fault_vec_o      <= chk_vec;
                        fault_code_o     <= new_q & RPL_MASK;
                        fault_new_task_o <= 1'b0;
                        state_q          <= S_FAULT;
                    end else begin
                        state_q <= S_COMMIT;
                    end
                end
                S_COMMIT: if (!nest_q || rsp_valid_i) state_q <= S_LOAD;
                S_LOAD: if (rsp_valid_i) begin
                    if (slot_q == LAST) begin
                        slot_q  <= '0;
                        state_q <= S_CHECK;
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end
                S_CHECK: if (rsp_valid_i) begin
                    if (chk_fail) begin
                        fault_vec_o      <= chk_vec;
                        fault_code_o     <= cur_sel_i & RPL_MASK;
                        fault_new_task_o <= 1'b1;
                        state_q          <= S_FAULT;
                    end else if (slot_q == LAST) begin
                        state_q <= S_DONE;
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/task_switch_seq.sv
// Top of the task switch commit sequencer: sequencer plus selector storage.
// Assumes a single outstanding memory request at a time.
module task_switch_seq #(
    parameter int SEL_W = 16,
    parameter int NSEG  = 7,
    localparam int SLOT_W = $clog2(NSEG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  nest_i,
    input  logic [SEL_W-1:0]      new_sel_i,
    input  logic [SEL_W-1:0]      old_sel_i,
    output logic                  req_valid_o,
    output logic [1:0]            req_kind_o,
    output logic [SEL_W-1:0]      req_addr_o,
    output logic [SEL_W-1:0]      req_wdata_o,
    input  logic                  rsp_valid_i,
    input  logic [SEL_W-1:0]      rsp_data_i,
    output logic [SEL_W-1:0]      tr_sel_o,
    output logic [NSEG*SEL_W-1:0] seg_sel_o,
    output logic                  done_o,
    output logic                  fault_o,
    output logic [7:0]            fault_vec_o,
    output logic [SEL_W-1:0]      fault_code_o,
    output logic                  fault_new_task_o
);
    logic [SLOT_W-1:0] slot;
    logic [SEL_W-1:0]  cur_sel;
    logic              tr_we, seg_we;

    tsc_fsm #(.SEL_W(SEL_W), .NSEG(NSEG)) u_fsm (
        .clk, .rst_n, .start_i, .nest_i, .new_sel_i, .old_sel_i,
        .req_valid_o, .req_kind_o, .req_addr_o, .req_wdata_o,
        .rsp_valid_i, .rsp_data_i,
        .cur_sel_i(cur_sel), .slot_o(slot), .tr_we_o(tr_we), .seg_we_o(seg_we),
        .done_o, .fault_o, .fault_vec_o, .fault_code_o, .fault_new_task_o
    );

    tsc_segfile #(.SEL_W(SEL_W), .NSEG(NSEG)) u_file (
        .clk, .rst_n,
        .tr_we_i(tr_we), .tr_wdata_i(req_addr_o),
        .seg_we_i(seg_we), .seg_widx_i(slot), .seg_wdata_i(rsp_data_i),
        .rd_idx_i(slot), .rd_sel_o(cur_sel),
        .tr_sel_o, .seg_flat_o(seg_sel_o)
    );
endmodule

// File: rtl/tsc_sva.sv
// Protocol and ordering checks for task_switch_seq, attached by bind.
module tsc_sva
    import tsc_pkg::*;
#(
    parameter int SEL_W = 16,
    parameter int NSEG  = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid_o,
    input logic [1:0]            req_kind_o,
    input logic [SEL_W-1:0]      req_addr_o,
    input logic                  rsp_valid_i,
    input logic [SEL_W-1:0]      tr_sel_o,
    input logic [NSEG*SEL_W-1:0] seg_sel_o,
    input logic                  done_o,
    input logic                  fault_o,
    input logic [7:0]            fault_vec_o,
    input logic                  fault_new_task_o
);
    p_tr_hold_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_kind_o == K_TSS) |-> $stable(tr_sel_o));
    p_link_tr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_kind_o == K_LINK) |-> tr_sel_o == req_addr_o);
    p_slots_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_kind_o == K_DESC) |=> $stable(seg_sel_o));
    p_ss_new_ctx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && fault_vec_o == V_SS) |-> fault_new_task_o);
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fault_o));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_fault_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !fault_o);
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !rsp_valid_i) |=>
            (req_valid_o && $stable(req_kind_o) && $stable(req_addr_o)));
endmodule

bind task_switch_seq tsc_sva #(.SEL_W(SEL_W), .NSEG(NSEG)) u_sva (
    .clk(clk), .rst_n(rst_n), .req_valid_o(req_valid_o), .req_kind_o(req_kind_o),
    .req_addr_o(req_addr_o), .rsp_valid_i(rsp_valid_i), .tr_sel_o(tr_sel_o),
    .seg_sel_o(seg_sel_o), .done_o(done_o), .fault_o(fault_o),
    .fault_vec_o(fault_vec_o), .fault_new_task_o(fault_new_task_o)
);

// File: tb/sim_task_switch_seq.sv
module sim_task_switch_seq;
    localparam int CLK_P = 10;
    localparam int NSEG  = 7;

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, nest_i = 1'b0;
    logic [15:0] new_sel_i = '0, old_sel_i = '0;
    logic req_valid_o, rsp_valid_i = 1'b0;
    logic [1:0] req_kind_o;
    logic [15:0] req_addr_o, req_wdata_o, rsp_data_i = '0, tr_sel_o, fault_code_o;
    logic [NSEG*16-1:0] seg_sel_o;
    logic done_o, fault_o, fault_new_task_o;
    logic [7:0] fault_vec_o;

    task_switch_seq u0 (.*);

    always #(CLK_P/2) clk = ~clk;

    int checks = 0, errors = 0, cycles = 0, rid = 0;
    int lat, cnt = 0, dcnt = 0, nlog = 0, unstable = 0;
    logic tss_p, tss_ok;
    logic desc_p [NSEG], desc_ok [NSEG];
    logic [15:0] sel_tab [NSEG];
    logic [1:0]  log_k [32];
    logic [15:0] log_a [32], log_w [32];
    logic [1:0]  hold_k;
    logic [15:0] hold_a;

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory responder: answers after lat waiting cycles, logs each answered request.
    always @(negedge clk) begin
        if (rsp_valid_i) begin
            rsp_valid_i = 1'b0;
            cnt = 0;
        end else if (req_valid_o) begin
            if (cnt > 0 && (req_kind_o != hold_k || req_addr_o != hold_a)) unstable++;
            hold_k = req_kind_o;
            hold_a = req_addr_o;
            if (cnt >= lat) begin
                case (req_kind_o)
                    2'd0: rsp_data_i = {14'b0, tss_ok, tss_p};
                    2'd2: rsp_data_i = sel_tab[req_addr_o[2:0]];
                    2'd3: begin
                        rsp_data_i = {14'b0, desc_ok[dcnt % NSEG], desc_p[dcnt % NSEG]};
                        dcnt++;
                    end
                    default: rsp_data_i = '0;
                endcase
                if (nlog < 32) begin
                    log_k[nlog] = req_kind_o;
                    log_a[nlog] = req_addr_o;
                    log_w[nlog] = req_wdata_o;
                end
                nlog++;
                rsp_valid_i = 1'b1;
            end else cnt++;
        end else cnt = 0;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // One switch: tss_case 0 ok / 1 not present / 2 limit; fslot 7 = no slot fails.
    task automatic run(input int tss_case, input int fslot, input int ftype, input bit nest);
        logic [15:0] prev_tr, new_s, old_s, e_code;
        logic [NSEG*16-1:0] prev_seg, e_seg;
        logic [7:0] e_vec;
        bit pre, got_d, got_f, log_ok;
        int e_len, bad;
        rid++;
        lat = rid % 3;
        prev_tr = tr_sel_o;
        prev_seg = seg_sel_o;
        tss_p  = (tss_case != 1);
        tss_ok = (tss_case == 0);
        for (int i = 0; i < NSEG; i++) begin
            sel_tab[i] = {rid[7:0], i[4:0], 3'b011};
            desc_p[i]  = !(i == fslot && ftype == 0);
            desc_ok[i] = !(i == fslot);
        end
        new_s = {rid[7:0] + 8'h80, 8'h2B};
        old_s = prev_tr;
        nlog = 0; dcnt = 0; unstable = 0;
        @(negedge clk);
        start_i = 1'b1; new_sel_i = new_s; old_sel_i = old_s; nest_i = nest;
        @(negedge clk);
        new_sel_i = 16'hDEAD; nest_i = !nest;   // busy: must be ignored (R9)
        @(negedge clk);
        start_i = 1'b0;
        got_d = 0; got_f = 0;
        for (int c = 0; c < 400; c++) begin
            if (done_o || fault_o) begin
                got_d = done_o; got_f = fault_o;
                break;
            end
            @(negedge clk);
        end
        pre = (tss_case != 0);
        e_vec = (tss_case == 1) ? 8'd11 : 8'd10;
        if (!pre && fslot < NSEG)
            e_vec = (fslot == 0) ? 8'd10 : (fslot == 1) ? 8'd12 : (ftype == 0) ? 8'd11 : 8'd10;
        e_code = pre ? (new_s & 16'hFFFC) : (fslot < NSEG ? sel_tab[fslot % NSEG] & 16'hFFFC : 16'h0);
        for (int i = 0; i < NSEG; i++) e_seg[i*16 +: 16] = sel_tab[i];
        if (pre) e_seg = prev_seg;
        chk(got_d == (!pre && fslot == NSEG) && got_f == (pre || fslot < NSEG), "R8 outcome",
            {got_d, got_f}, {(!pre && fslot == NSEG), (pre || fslot < NSEG)});
        if (got_f) begin
            chk(fault_vec_o == e_vec, pre ? "R2 vector" : "R6 vector", fault_vec_o, e_vec);
            chk(fault_code_o == e_code, pre ? "R2 code" : "R6 code", fault_code_o, e_code);
            chk(fault_new_task_o == !pre, pre ? "R2 context" : "R7 context", fault_new_task_o, !pre);
        end
        chk(tr_sel_o == (pre ? prev_tr : new_s), pre ? "R2 tr kept" : "R3 tr loaded",
            tr_sel_o, pre ? prev_tr : new_s);
        chk(seg_sel_o == e_seg, pre ? "R2 slots kept" : "R7 slots loaded", seg_sel_o, e_seg);
        e_len = pre ? 1 : 1 + int'(nest) + NSEG + (fslot < NSEG ? fslot + 1 : NSEG);
        chk(nlog == e_len, "R5 request count", nlog, e_len);
        log_ok = (log_k[0] == 2'd0 && log_a[0] == new_s);
        bad = 0;
        if (!pre && nlog == e_len) begin
            int p = 1;
            if (nest) begin
                if (!(log_k[1] == 2'd1 && log_a[1] == new_s && log_w[1] == old_s)) bad = 1;
                p = 2;
            end
            for (int i = 0; i < NSEG; i++)
                if (!(log_k[p+i] == 2'd2 && log_a[p+i] == 16'(i))) bad = 2;
            for (int i = 0; i < e_len - p - NSEG; i++)
                if (!(log_k[p+NSEG+i] == 2'd3 && log_a[p+NSEG+i] == sel_tab[i])) bad = 3;
        end
        chk(log_ok, "R2 first request", {log_k[0], log_a[0]}, {2'd0, new_s});
        chk(bad != 1, "R3 link write", {log_k[nest ? 1 : 0], log_a[nest ? 1 : 0], log_w[nest ? 1 : 0]},
            {2'd1, new_s, old_s});
        chk(bad != 2, "R4 load order", bad, 0);
        chk(bad != 3, "R5 check order", bad, 0);
        chk(unstable == 0, "R9 request hold", unstable, 0);
        @(negedge clk);
        chk(!done_o && !fault_o, "R8 single pulse", {done_o, fault_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req_valid_o && !done_o && !fault_o, "R1 idle outputs",
            {req_valid_o, done_o, fault_o}, 0);
        chk(tr_sel_o == 0 && seg_sel_o == 0, "R1 cleared state", {tr_sel_o, seg_sel_o}, 0);
        for (int n = 0; n < 2; n++) begin
            for (int t = 1; t <= 2; t++) run(t, NSEG, 0, n[0]);
            for (int f = 0; f < NSEG; f++)
                for (int ty = 0; ty < 2; ty++) run(0, f, ty, n[0]);
            run(0, NSEG, 0, n[0]);
            run(1, NSEG, 0, n[0]);   // pre-commit after a committed switch
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule